// File: doc/BRIEF.md
# Supply Window Fault Detector with Release Hysteresis

This block checks a sampled, unsigned supply reading against a programmable lower bound and a programmable upper bound on every clock. It raises an undervoltage flag when the reading drops under the lower bound and an overvoltage flag when the reading climbs over the upper bound. Each clock is treated as one new sample, and each flag is a register that follows its sample by exactly one clock.

A flag does not clear at the level that set it. Once a flag is set, it is released only when the reading has moved back past the trip level by a hysteresis margin. This stops a reading that hovers near a bound from toggling the flag. The margin is chosen by a 5-bit code and scales with the full-scale value of the reading: margin = floor(fullScale * code / 255). The trip levels themselves never move. The release levels are clamped to the valid reading range, so they never wrap. Driving the enable low clears both flags and holds them clear.

Top module: `window_fault_detector`

## Requirements
- R1: While rstN is low, and in the first cycle after it is released, uvFlag and ovFlag are both 0.
- R2: With enable high, a sample strictly below uvThresh sets uvFlag to 1 at the next rising clock edge.
- R3: Once uvFlag is 1, it stays 1 while enable is high and the sample is at or below the UV release level, uvThresh + margin. It clears at the edge after a sample strictly above that level.
- R4: With enable high, a sample strictly above ovThresh sets ovFlag to 1 at the next rising clock edge.
- R5: Once ovFlag is 1, it stays 1 while enable is high and the sample is at or above the OV release level, ovThresh - margin. It clears at the edge after a sample strictly below that level.
- R6: The margin is floor((2^DATA_W - 1) * hystCode / 255), where hystCode is the 5-bit code (0 to 31). With DATA_W = 10, codes 1, 16 and 31 give margins of 4, 64 and 124.
- R7: The UV release level saturates at 2^DATA_W - 1 and the OV release level saturates at 0. Neither wraps, so a flag whose release level sits at a range end stays set until enable drops.
- R8: With hystCode = 0, the release levels equal the thresholds. uvFlag clears after a sample above uvThresh, and ovFlag clears after a sample below ovThresh.
- R9: With enable low, both flags are 0 after the next rising edge, whatever the sample.
- R10: The hysteresis code has no effect on setting a flag. A sample equal to a threshold never sets a flag, at any code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one sample per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Detection enable; low clears both flags |
| sample | input | DATA_W | Unsigned supply reading |
| uvThresh | input | DATA_W | Undervoltage trip level |
| ovThresh | input | DATA_W | Overvoltage trip level |
| hystCode | input | 5 | Hysteresis code, 0 to 31 |
| uvFlag | output | 1 | Registered undervoltage flag |
| ovFlag | output | 1 | Registered overvoltage flag |

## Verification
The assertions assume the threshold and code inputs are stable and defined at each sampling edge. They also assume each flag's trip and release conditions are mutually exclusive, which holds for any threshold values because each release level is clamped onto the far side of its trip level. The stimulus drives all inputs on the falling edge, so every sampling edge sees settled values. The random phase holds the thresholds and code fixed for runs of cycles, then draws new ones. Samples are drawn near the active thresholds and their release levels, including the range ends, so that both the hold band and the saturated cases are visited often.

// File: rtl/wfd_pkg.sv
package wfd_pkg;
  localparam int CODE_W = 5;
  localparam int CODE_DIV = 255;

  typedef struct packed {
    logic uvTrip;
    logic uvRelease;
    logic ovTrip;
    logic ovRelease;
  } cmpStrobes_t;
endpackage

// File: rtl/wfd_datapath.sv
module wfd_datapath
  import wfd_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] uvThresh,
  input  logic [DATA_W-1:0] ovThresh,
  input  logic [CODE_W-1:0] hystCode,
  output cmpStrobes_t       strobes
);
  localparam int FULL_SCALE = (1 << DATA_W) - 1;
  localparam int PROD_W     = DATA_W + CODE_W;
  localparam int EXT_W      = DATA_W + 1;

  logic [PROD_W-1:0] scaled;
  logic [PROD_W-1:0] quot;
  logic [DATA_W-1:0] hystVal;
  logic [EXT_W-1:0]  uvSum;
  logic [DATA_W-1:0] uvRelLvl;
  logic [DATA_W-1:0] ovRelLvl;

  // margin = fullScale * code / 255, floor
  always_comb begin
    scaled  = PROD_W'(FULL_SCALE) * PROD_W'(hystCode);
    quot    = scaled / PROD_W'(CODE_DIV);
    hystVal = quot[DATA_W-1:0];
  end

  // release levels, clamped at the range ends
  always_comb begin
    uvSum    = {1'b0, uvThresh} + {1'b0, hystVal};
    uvRelLvl = uvSum[DATA_W] ? DATA_W'(FULL_SCALE) : uvSum[DATA_W-1:0];
    ovRelLvl = (hystVal > ovThresh) ? '0 : (ovThresh - hystVal);
  end

  always_comb begin
    strobes.uvTrip    = sample < uvThresh;
    strobes.uvRelease = sample > uvRelLvl;
    strobes.ovTrip    = sample > ovThresh;
    strobes.ovRelease = sample < ovRelLvl;
  end

  always_comb begin
    a_r7_uv_no_wrap: assert (uvRelLvl >= uvThresh)
      else $error("UV release level below its threshold");
    a_r7_ov_no_wrap: assert (ovRelLvl <= ovThresh)
      else $error("OV release level above its threshold");
  end
endmodule

// File: rtl/wfd_control.sv
module wfd_control
  import wfd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  cmpStrobes_t strobes,
  output logic        uvFlag,
  output logic        ovFlag
);
  logic uvNext;
  logic ovNext;

  always_comb begin
    uvNext = uvFlag;
    ovNext = ovFlag;
    if (!enable) begin
      uvNext = 1'b0;
      ovNext = 1'b0;
    end else begin
      if (uvFlag) uvNext = !strobes.uvRelease;
      else        uvNext = strobes.uvTrip;
      if (ovFlag) ovNext = !strobes.ovRelease;
      else        ovNext = strobes.ovTrip;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      uvFlag <= 1'b0;
      ovFlag <= 1'b0;
    end else begin
      uvFlag <= uvNext;
      ovFlag <= ovNext;
    end
  end

  a_r2_uv_sets: assert property (@(posedge clk) disable iff (!rstN)
    (enable && strobes.uvTrip) |=> uvFlag);
  a_r3_uv_holds: assert property (@(posedge clk) disable iff (!rstN)
    (enable && uvFlag && !strobes.uvRelease) |=> uvFlag);
  a_r4_ov_sets: assert property (@(posedge clk) disable iff (!rstN)
    (enable && strobes.ovTrip) |=> ovFlag);
  a_r5_ov_holds: assert property (@(posedge clk) disable iff (!rstN)
    (enable && ovFlag && !strobes.ovRelease) |=> ovFlag);
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!uvFlag && !ovFlag));
  a_r10_uv_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uvFlag) |-> $past(enable && strobes.uvTrip));
  a_r10_ov_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovFlag) |-> $past(enable && strobes.ovTrip));
endmodule

// File: rtl/window_fault_detector.sv
module window_fault_detector
  import wfd_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] uvThresh,
  input  logic [DATA_W-1:0] ovThresh,
  input  logic [4:0]        hystCode,
  output logic              uvFlag,
  output logic              ovFlag
);
  cmpStrobes_t strobes;

  wfd_datapath #(.DATA_W(DATA_W)) uDatapath (
    .sample   (sample),
    .uvThresh (uvThresh),
    .ovThresh (ovThresh),
    .hystCode (hystCode),
    .strobes  (strobes)
  );

  wfd_control uControl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .strobes (strobes),
    .uvFlag  (uvFlag),
    .ovFlag  (ovFlag)
  );
endmodule

// File: tb/window_fault_detector_test.sv
`timescale 1ns/1ps
module window_fault_detector_test;
  localparam int DW = 10;
  localparam int FS = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic [DW-1:0] sample = '0;
  logic [DW-1:0] uvThresh = '0;
  logic [DW-1:0] ovThresh = '0;
  logic [4:0]    hystCode = '0;
  logic          uvFlag;
  logic          ovFlag;

  int errors = 0;
  int checks = 0;
  bit expUv = 1'b0;
  bit expOv = 1'b0;
  bit finished = 1'b0;

  window_fault_detector #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .sample(sample),
    .uvThresh(uvThresh), .ovThresh(ovThresh), .hystCode(hystCode),
    .uvFlag(uvFlag), .ovFlag(ovFlag)
  );

  always #10 clk = ~clk;

  function automatic int marginOf(input int code);
    return (FS * code) / 255;
  endfunction

  function automatic int uvRel(input int thr, input int code);
    int v = thr + marginOf(code);
    return (v > FS) ? FS : v;
  endfunction

  function automatic int ovRel(input int thr, input int code);
    int v = thr - marginOf(code);
    return (v < 0) ? 0 : v;
  endfunction

  task automatic check(input string tag, input bit gotUv, input bit wantUv,
                       input bit gotOv, input bit wantOv);
    checks++;
    if (gotUv !== wantUv || gotOv !== wantOv) begin
      errors++;
      $display("FAIL %s: uv/ov actual=%0b/%0b expected=%0b/%0b",
               tag, gotUv, gotOv, wantUv, wantOv);
    end
  endtask

  // called at a falling edge: drive, let the rising edge pass, check
  task automatic step(input int s, input int uvt, input int ovt, input int code,
                      input bit en, input string tag);
    sample = DW'(s); uvThresh = DW'(uvt); ovThresh = DW'(ovt);
    hystCode = 5'(code); enable = en;
    @(posedge clk);
    if (!en) begin
      expUv = 1'b0; expOv = 1'b0;
    end else begin
      expUv = expUv ? !(s > uvRel(uvt, code)) : (s < uvt);
      expOv = expOv ? !(s < ovRel(ovt, code)) : (s > ovt);
    end
    @(negedge clk);
    check(tag, uvFlag, expUv, ovFlag, expOv);
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check("R1 in reset", uvFlag, 1'b0, ovFlag, 1'b0);
    rstN = 1'b1;
    step(500, 400, 700, 16, 1'b1, "R1 after reset");

    // R6 margin 64 at code 16
    step(399, 400, 700, 16, 1'b1, "R2 uv sets");
    step(430, 400, 700, 16, 1'b1, "R3 uv holds in band");
    step(464, 400, 700, 16, 1'b1, "R3 uv holds at release level");
    step(465, 400, 700, 16, 1'b1, "R3 uv clears above release");
    step(400, 400, 700, 31, 1'b1, "R10 equal to uv threshold");
    step(700, 400, 700, 31, 1'b1, "R10 equal to ov threshold");
    step(701, 400, 700, 16, 1'b1, "R4 ov sets");
    step(650, 400, 700, 16, 1'b1, "R5 ov holds in band");
    step(636, 400, 700, 16, 1'b1, "R5 ov holds at release level");
    step(635, 400, 700, 16, 1'b1, "R5 ov clears below release");

    step(399, 400, 700, 0, 1'b1, "R8 uv sets code 0");
    step(400, 400, 700, 0, 1'b1, "R8 uv holds at threshold");
    step(401, 400, 700, 0, 1'b1, "R8 uv clears code 0");
    step(701, 400, 700, 0, 1'b1, "R8 ov sets code 0");
    step(699, 400, 700, 0, 1'b1, "R8 ov clears code 0");

    step(399, 400, 700, 1, 1'b1, "R6 uv sets code 1");
    step(404, 400, 700, 1, 1'b1, "R6 margin 4 holds");
    step(405, 400, 700, 1, 1'b1, "R6 margin 4 clears");
    step(701, 400, 700, 31, 1'b1, "R6 ov sets code 31");
    step(576, 400, 700, 31, 1'b1, "R6 margin 124 holds");
    step(575, 400, 700, 31, 1'b1, "R6 margin 124 clears");

    step(5, 1000, 1023, 31, 1'b1, "R7 uv sets near top");
    step(1023, 1000, 1023, 31, 1'b1, "R7 uv release saturated");
    step(1023, 1000, 1023, 31, 1'b0, "R9 disable clears uv");
    step(0, 1000, 1023, 31, 1'b0, "R9 disabled ignores low sample");
    step(60, 0, 50, 31, 1'b1, "R7 ov sets near bottom");
    step(0, 0, 50, 31, 1'b1, "R7 ov release saturated");
    step(0, 0, 50, 31, 1'b0, "R9 disable clears ov");
    step(1023, 0, 50, 31, 1'b0, "R9 disabled ignores high sample");

    for (int blk = 0; blk < 150; blk++) begin
      int uvt = $urandom_range(0, FS);
      int ovt = $urandom_range(0, FS);
      int code = $urandom_range(0, 31);
      for (int k = 0; k < 20; k++) begin
        int pick = $urandom_range(0, 5);
        int base = (pick == 0) ? uvt : (pick == 1) ? uvRel(uvt, code) :
                   (pick == 2) ? ovt : (pick == 3) ? ovRel(ovt, code) :
                   (pick == 4) ? 0 : FS;
        int s = base + $urandom_range(0, 6) - 3;
        bit en = ($urandom_range(0, 31) != 0);
        if (s < 0) s = 0;
        if (s > FS) s = FS;
        step(s, uvt, ovt, code, en, "R2/R3/R4/R5 random");
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule